// File: doc/BRIEF.md
# Load Queue with Memory-Order Violation Detection

This block keeps the in-flight loads of an out-of-order core in a circular queue, ordered oldest at the head and youngest at the tail. Each load is allocated at the tail with its sequence number. Its effective address is filled in later by index, once address generation finishes. Loads retire from the head when the commit stage reports a sequence number. When a misprediction or exception discards younger work, a squash removes loads from the tail.

When a store resolves its address, the store's sequence number and address are presented as a probe. The queue looks only at loads younger than the store that already have an address. It compares them at 256-byte granularity and picks the oldest that matches. A violation is reported when no violator is held yet, or when this load is older than the held one. The held record is dropped by a squash that reaches back past it. The core reads the held sequence number and uses it to decide where to refetch.

The queue accepts one command per cycle. A squash outranks a commit, which outranks an allocation, then an address update, then a probe. A lower command presented alongside a higher one is dropped.

Top module: `load_order_queue`

## Requirements
- R1: After reset the occupancy is 0, allocReady is 1, allocIdx is 0, and violHeld and violPulse are 0.
- R2: An allocation writes the load at slot allocIdx, raises occupancy by one and advances allocIdx by one. allocIdx goes from DEPTH-1 back to 0. When occupancy equals DEPTH, allocReady is 0 and an allocation is refused with no change.
- R3: A commit with sequence number C retires loads from the head, oldest first, while the queue is non-empty and the head load's sequence number is at most C. It stops at the first load above C.
- R4: A squash with sequence number S removes loads from the tail backwards while the queue is non-empty and the tail load's sequence number exceeds S. allocIdx steps back by one per removed load, going from 0 to DEPTH-1.
- R5: A probe with store sequence number P considers only loads whose sequence number is greater than P.
- R6: Only loads whose address has been written since their allocation take part in a probe. A new allocation marks its slot's address as not written. An address update aimed at an unoccupied slot is dropped.
- R7: A load conflicts with a probe when its address and the probe address are equal in every bit above bit 7. This gives 256-byte granularity.
- R8: Of the conflicting loads, the oldest is the candidate. If no violator is held, or the candidate's sequence number is below violSeq, then violSeq takes the candidate's value, violHeld is set, and violPulse is 1 for the single cycle after the probe. Otherwise violSeq is unchanged and violPulse stays 0.
- R9: A squash with sequence number S clears violHeld when S is below violSeq.
- R10: At most one command acts per cycle, with priority squash, commit, allocation, address update, probe. Lower commands in the same cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocate a load at the tail |
| allocSeq | input | SEQ_W | Sequence number of the allocated load |
| allocReady | output | 1 | Queue has a free slot |
| allocIdx | output | IDX_W | Slot the next allocation will use (tail) |
| addrValid | input | 1 | Write an effective address into a slot |
| addrIdx | input | IDX_W | Slot to receive the address |
| addrVal | input | ADDR_W | Effective address |
| commitValid | input | 1 | Retire loads up to commitSeq |
| commitSeq | input | SEQ_W | Youngest committed sequence number |
| squashValid | input | 1 | Discard loads above squashSeq |
| squashSeq | input | SEQ_W | Last surviving sequence number |
| probeValid | input | 1 | Store-address ordering check |
| probeSeq | input | SEQ_W | Sequence number of the store |
| probeAddr | input | ADDR_W | Effective address of the store |
| occupancy | output | IDX_W+1 | Number of loads held |
| violPulse | output | 1 | One-cycle pulse when a new violator is recorded |
| violHeld | output | 1 | A violator record is held |
| violSeq | output | SEQ_W | Sequence number of the held violator |

## Verification
The case that is hardest to reach from the ports is a probe that matches several loads at once. In that case the oldest match must win, and it must also be compared against an earlier held violator. Reaching it requires a queue whose head and tail have both wrapped. The stimulus fills the queue, partly commits it and refills it. It then places addresses so that three loads share one 256-byte window, one load older than the store matches, and one load has no address. Later probes replace the record with an older load, and squashes both keep and clear it. A squash that is followed by reuse of a slot with a stale address checks that allocation invalidates the old address.

// File: rtl/lq_pkg.sv
package lq_pkg;
  typedef struct packed {
    logic alloc;
    logic setAddr;
    logic commit;
    logic squash;
    logic probe;
  } lqStrobe_t;
endpackage

// File: rtl/lq_data.sv
module lq_data
  import lq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int GRAN   = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  lqStrobe_t         strobe,
  input  logic [IDX_W-1:0]  head,
  input  logic [IDX_W-1:0]  tail,
  input  logic [CNT_W-1:0]  count,
  input  logic [SEQ_W-1:0]  allocSeq,
  input  logic [IDX_W-1:0]  addrIdx,
  input  logic [ADDR_W-1:0] addrVal,
  input  logic [SEQ_W-1:0]  commitSeq,
  input  logic [SEQ_W-1:0]  squashSeq,
  input  logic [SEQ_W-1:0]  probeSeq,
  input  logic [ADDR_W-1:0] probeAddr,
  output logic [CNT_W-1:0]  commitN,
  output logic [CNT_W-1:0]  squashN,
  output logic              hitFound,
  output logic [SEQ_W-1:0]  hitSeq
);
  logic [SEQ_W-1:0]  seqMem  [DEPTH];
  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [DEPTH-1:0]  addrOk;

  function automatic logic [IDX_W-1:0] slotAt(input logic [IDX_W-1:0] base,
                                              input logic [CNT_W-1:0] off);
    logic [CNT_W:0] s;
    s = {1'b0, {1'b0, base} + off};
    if (s >= (CNT_W+1)'(DEPTH)) s = s - (CNT_W+1)'(DEPTH);
    if (s >= (CNT_W+1)'(DEPTH)) s = s - (CNT_W+1)'(DEPTH);
    return s[IDX_W-1:0];
  endfunction

  function automatic logic sameBlock(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] b);
    return ((a ^ b) >> GRAN) == '0;
  endfunction

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : gSlot
      always_ff @(posedge clk) begin
        if (!rstN) begin
          seqMem[g]  <= '0;
          addrMem[g] <= '0;
          addrOk[g]  <= 1'b0;
        end else if (strobe.alloc && tail == IDX_W'(g)) begin
          seqMem[g] <= allocSeq;
          addrOk[g] <= 1'b0;
        end else if (strobe.setAddr && addrIdx == IDX_W'(g)) begin
          addrMem[g] <= addrVal;
          addrOk[g]  <= 1'b1;
        end
      end
    end
  endgenerate

  // Retire count: leading run (from head) of loads at or below commitSeq
  always_comb begin
    logic stop;
    logic [IDX_W-1:0] s;
    commitN = '0;
    stop = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      s = slotAt(head, CNT_W'(i));
      if (!stop && CNT_W'(i) < count && seqMem[s] <= commitSeq) commitN = commitN + 1'b1;
      else stop = 1'b1;
    end
    if (!strobe.commit) commitN = '0;
  end

  // Squash count: trailing run (from tail) of loads above squashSeq
  always_comb begin
    logic stop;
    logic [IDX_W-1:0] s;
    squashN = '0;
    stop = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      s = slotAt(tail, CNT_W'(DEPTH - 1 - i));
      if (!stop && CNT_W'(i) < count && seqMem[s] > squashSeq) squashN = squashN + 1'b1;
      else stop = 1'b1;
    end
    if (!strobe.squash) squashN = '0;
  end

  // Oldest younger load with a valid address in the same 256-byte block
  always_comb begin
    logic [IDX_W-1:0] s;
    hitFound = 1'b0;
    hitSeq   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      s = slotAt(head, CNT_W'(i));
      if (!hitFound && CNT_W'(i) < count && seqMem[s] > probeSeq &&
          addrOk[s] && sameBlock(addrMem[s], probeAddr)) begin
        hitFound = 1'b1;
        hitSeq   = seqMem[s];
      end
    end
    if (!strobe.probe) hitFound = 1'b0;
  end
endmodule

// File: rtl/lq_ctrl.sv
module lq_ctrl
  import lq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic             addrValid,
  input  logic [IDX_W-1:0] addrIdx,
  input  logic             commitValid,
  input  logic             squashValid,
  input  logic [SEQ_W-1:0] squashSeq,
  input  logic             probeValid,
  input  logic [CNT_W-1:0] commitN,
  input  logic [CNT_W-1:0] squashN,
  input  logic             hitFound,
  input  logic [SEQ_W-1:0] hitSeq,
  output lqStrobe_t        strobe,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             violPulse,
  output logic             violHeld,
  output logic [SEQ_W-1:0] violSeq
);
  logic occupied;
  logic [CNT_W-1:0] addrOff;
  logic newViol;

  function automatic logic [IDX_W-1:0] wrapAdd(input logic [IDX_W-1:0] base,
                                               input logic [CNT_W-1:0] off);
    logic [CNT_W:0] s;
    s = {1'b0, {1'b0, base} + off};
    if (s >= (CNT_W+1)'(DEPTH)) s = s - (CNT_W+1)'(DEPTH);
    return s[IDX_W-1:0];
  endfunction

  always_comb begin
    if (addrIdx >= head) addrOff = CNT_W'(addrIdx) - CNT_W'(head);
    else                 addrOff = CNT_W'(addrIdx) + CNT_W'(DEPTH) - CNT_W'(head);
    occupied = (CNT_W'(addrIdx) < CNT_W'(DEPTH)) && (addrOff < count);
  end

  always_comb begin
    strobe.squash  = squashValid;
    strobe.commit  = commitValid && !squashValid;
    strobe.alloc   = allocValid && !squashValid && !commitValid &&
                     (count < CNT_W'(DEPTH));
    strobe.setAddr = addrValid && !squashValid && !commitValid && !allocValid && occupied;
    strobe.probe   = probeValid && !squashValid && !commitValid && !allocValid && !addrValid;
  end

  assign newViol = hitFound && (!violHeld || hitSeq < violSeq);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      head      <= '0;
      tail      <= '0;
      count     <= '0;
      violPulse <= 1'b0;
      violHeld  <= 1'b0;
      violSeq   <= '0;
    end else begin
      violPulse <= 1'b0;
      if (strobe.squash) begin
        tail  <= wrapAdd(tail, CNT_W'(DEPTH) - squashN);
        count <= count - squashN;
        if (violHeld && squashSeq < violSeq) violHeld <= 1'b0;
      end else if (strobe.commit) begin
        head  <= wrapAdd(head, commitN);
        count <= count - commitN;
      end else if (strobe.alloc) begin
        tail  <= wrapAdd(tail, CNT_W'(1));
        count <= count + 1'b1;
      end else if (newViol) begin
        violHeld  <= 1'b1;
        violSeq   <= hitSeq;
        violPulse <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/load_order_queue.sv
module load_order_queue
  import lq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int GRAN   = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [SEQ_W-1:0]  allocSeq,
  output logic              allocReady,
  output logic [IDX_W-1:0]  allocIdx,
  input  logic              addrValid,
  input  logic [IDX_W-1:0]  addrIdx,
  input  logic [ADDR_W-1:0] addrVal,
  input  logic              commitValid,
  input  logic [SEQ_W-1:0]  commitSeq,
  input  logic              squashValid,
  input  logic [SEQ_W-1:0]  squashSeq,
  input  logic              probeValid,
  input  logic [SEQ_W-1:0]  probeSeq,
  input  logic [ADDR_W-1:0] probeAddr,
  output logic [CNT_W-1:0]  occupancy,
  output logic              violPulse,
  output logic              violHeld,
  output logic [SEQ_W-1:0]  violSeq
);
  lqStrobe_t strobe;
  logic [IDX_W-1:0] head, tail;
  logic [CNT_W-1:0] count, commitN, squashN;
  logic hitFound;
  logic [SEQ_W-1:0] hitSeq;

  lq_ctrl #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) uCtrl (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .addrValid(addrValid),
    .addrIdx(addrIdx), .commitValid(commitValid), .squashValid(squashValid),
    .squashSeq(squashSeq), .probeValid(probeValid), .commitN(commitN),
    .squashN(squashN), .hitFound(hitFound), .hitSeq(hitSeq), .strobe(strobe),
    .head(head), .tail(tail), .count(count), .violPulse(violPulse),
    .violHeld(violHeld), .violSeq(violSeq)
  );

  lq_data #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .GRAN(GRAN)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .head(head), .tail(tail),
    .count(count), .allocSeq(allocSeq), .addrIdx(addrIdx), .addrVal(addrVal),
    .commitSeq(commitSeq), .squashSeq(squashSeq), .probeSeq(probeSeq),
    .probeAddr(probeAddr), .commitN(commitN), .squashN(squashN),
    .hitFound(hitFound), .hitSeq(hitSeq)
  );

  assign allocReady = count < CNT_W'(DEPTH);
  assign allocIdx   = tail;
  assign occupancy  = count;
endmodule

// File: rtl/lq_checker.sv
module lq_checker #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             allocValid,
  input logic             allocReady,
  input logic             commitValid,
  input logic             squashValid,
  input logic [SEQ_W-1:0] squashSeq,
  input logic             probeValid,
  input logic [CNT_W-1:0] occupancy,
  input logic             violPulse,
  input logic             violHeld,
  input logic [SEQ_W-1:0] violSeq
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= CNT_W'(DEPTH)); // R2
  AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && !allocReady && !squashValid && !commitValid) |=> $stable(occupancy)); // R2
  AST_ALLOC_GROW: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && allocReady && !squashValid && !commitValid) |=> occupancy == $past(occupancy) + 1'b1); // R10
  AST_COMMIT_SHRINK: assert property (@(posedge clk) disable iff (!rstN)
    (commitValid && !squashValid) |=> occupancy <= $past(occupancy)); // R3
  AST_SQUASH_SHRINK: assert property (@(posedge clk) disable iff (!rstN)
    squashValid |=> occupancy <= $past(occupancy)); // R4
  AST_PULSE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    violPulse |-> violHeld); // R8
  AST_SQUASH_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (squashValid && violHeld && squashSeq < violSeq) |=> !violHeld); // R9
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (probeValid && occupancy == '0) |=> !violPulse); // R5
endmodule

bind load_order_queue lq_checker #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) uChk (
  .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocReady(allocReady),
  .commitValid(commitValid), .squashValid(squashValid), .squashSeq(squashSeq),
  .probeValid(probeValid), .occupancy(occupancy), .violPulse(violPulse),
  .violHeld(violHeld), .violSeq(violSeq)
);

// File: tb/tb_load_order_queue.sv
module tb_load_order_queue;
  localparam int DEPTH = 8, SEQ_W = 16, ADDR_W = 32;
  localparam int IDX_W = $clog2(DEPTH), CNT_W = IDX_W + 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic allocValid = 0, addrValid = 0, commitValid = 0, squashValid = 0, probeValid = 0;
  logic [SEQ_W-1:0] allocSeq = '0, commitSeq = '0, squashSeq = '0, probeSeq = '0;
  logic [IDX_W-1:0] addrIdx = '0;
  logic [ADDR_W-1:0] addrVal = '0, probeAddr = '0;
  logic allocReady, violPulse, violHeld;
  logic [IDX_W-1:0] allocIdx;
  logic [CNT_W-1:0] occupancy;
  logic [SEQ_W-1:0] violSeq;
  int nChecks = 0, nErrors = 0;

  always #4 clk = ~clk;

  load_order_queue dut (.*);

  task automatic check(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearAll();
    allocValid = 0; addrValid = 0; commitValid = 0; squashValid = 0; probeValid = 0;
  endtask

  task automatic doAlloc(input int s);
    @(negedge clk); allocValid = 1; allocSeq = SEQ_W'(s);
    @(negedge clk); clearAll();
  endtask
  task automatic doAddr(input int idx, input int a);
    @(negedge clk); addrValid = 1; addrIdx = IDX_W'(idx); addrVal = ADDR_W'(a);
    @(negedge clk); clearAll();
  endtask
  task automatic doCommit(input int s);
    @(negedge clk); commitValid = 1; commitSeq = SEQ_W'(s);
    @(negedge clk); clearAll();
  endtask
  task automatic doSquash(input int s);
    @(negedge clk); squashValid = 1; squashSeq = SEQ_W'(s);
    @(negedge clk); clearAll();
  endtask
  task automatic doProbe(input int s, input int a);
    @(negedge clk); probeValid = 1; probeSeq = SEQ_W'(s); probeAddr = ADDR_W'(a);
    @(negedge clk); clearAll();
  endtask

  task automatic testReset();
    check("R1 occupancy", occupancy, 0);
    check("R1 allocReady", allocReady, 1);
    check("R1 allocIdx", allocIdx, 0);
    check("R1 violHeld", violHeld, 0);
    check("R1 violPulse", violPulse, 0);
  endtask

  task automatic testFillWrap();
    for (int k = 0; k < DEPTH; k++) begin
      check("R2 allocIdx step", allocIdx, k);
      doAlloc(10 * (k + 1));
    end
    check("R2 full occupancy", occupancy, DEPTH);
    check("R2 full not ready", allocReady, 0);
    check("R2 tail wrapped", allocIdx, 0);
    doAlloc(90);
    check("R2 refused when full", occupancy, DEPTH);
  endtask

  task automatic testCommit();
    doCommit(35);
    check("R3 partial retire", occupancy, 5);
    for (int k = 0; k < 3; k++) begin
      check("R2 refill idx", allocIdx, k);
      doAlloc(90 + 10 * k);
    end
    check("R2 refill occupancy", occupancy, 8);
  endtask

  task automatic testProbe();
    // slots: 3:40 4:50 5:60 6:70 7:80 0:90 1:100 2:110
    doAddr(3, 'h1000);
    doAddr(5, 'h2010);
    doAddr(7, 'h20FF);
    doAddr(1, 'h2000);
    doProbe(55, 'h2080);
    check("R8 oldest match pulse", violPulse, 1);
    check("R8 oldest match seq", violSeq, 60);
    doProbe(45, 'h10F0);
    check("R5 older load ignored", violPulse, 0);
    doProbe(85, 'h00);
    check("R6 no-address load ignored", violPulse, 0);
    doProbe(85, 'h2100);
    check("R7 other block no match", violPulse, 0);
    doProbe(85, 'h20FF);
    check("R8 younger than held no pulse", violPulse, 0);
    check("R8 held seq kept", violSeq, 60);
  endtask

  task automatic testSquash();
    doSquash(55);
    check("R4 squash occupancy", occupancy, 2);
    check("R4 tail stepped back", allocIdx, 5);
    check("R9 violator cleared", violHeld, 0);
    doAlloc(56);
    doProbe(45, 'h2010);
    check("R6 stale address invalid", violPulse, 0);
    doAddr(5, 'h2020);
    doProbe(45, 'h20AA);
    check("R8 new violator", violSeq, 56);
    check("R8 new violator pulse", violPulse, 1);
    doAddr(4, 'h2050);
    doProbe(45, 'h2000);
    check("R8 older replaces", violSeq, 50);
    doProbe(45, 'h2000);
    check("R8 equal no pulse", violPulse, 0);
    doSquash(52);
    check("R4 one removed", occupancy, 2);
    check("R9 violator kept", violHeld, 1);
    check("R9 violator seq kept", violSeq, 50);
  endtask

  task automatic testPriority();
    @(negedge clk); squashValid = 1; squashSeq = 100; allocValid = 1; allocSeq = 60;
    @(negedge clk); clearAll();
    check("R10 alloc under squash", occupancy, 2);
    @(negedge clk); commitValid = 1; commitSeq = 45; allocValid = 1; allocSeq = 60;
    @(negedge clk); clearAll();
    check("R10 alloc under commit", occupancy, 1);
    check("R10 tail unchanged", allocIdx, 5);
  endtask

  task automatic testDrain();
    doCommit(1000);
    check("R3 drain", occupancy, 0);
    check("R2 ready after drain", allocReady, 1);
    doCommit(5);
    check("R3 commit on empty", occupancy, 0);
    doProbe(0, 'h2000);
    check("R5 probe on empty", violPulse, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFillWrap();
    testCommit();
    testProbe();
    testSquash();
    testPriority();
    testDrain();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    #200000;
    nChecks++; nErrors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule